// File: doc/BRIEF.md
# Serial Flash Range Erase Sequencer

This block erases a byte range of a page-organized serial flash by driving a byte-level SPI master. Software supplies a start byte address, a byte length, the device size, the page size (it need not be a power of two), the number of bit positions by which a page index is shifted to form the device address, a poll spacing and a poll limit. The block checks the request and converts the start and the length into page counts with two small serial dividers. It then erases the range one step at a time, using an eight-page block erase where alignment and the remaining length allow and a single-page erase elsewhere.

Each erase command is one framed 4-byte transfer. The device then runs its erase internally. The block reads the status byte in its own separate frames, spaced by a programmable number of idle cycles, until the ready flag is set. It then moves to the next step. A one-cycle `done` pulse marks success. A one-cycle `fail` pulse marks a rejected request or a device that stayed busy for too many polls.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with start address plus length greater than `dev_bytes` is rejected with a `fail` pulse, and no SPI frame is sent.
- R2: A request is rejected with a `fail` pulse and no SPI frame when the page size is zero, when the start is not a whole multiple of the page size, or when the length is not a whole multiple of the page size.
- R3: A step uses block erase (opcode 0x50) when the current page index is a multiple of 8 and at least 8 pages remain. Otherwise it uses page erase (opcode 0x81).
- R4: Each erase frame is exactly 4 bytes. The bytes are the opcode, then bits [23:16] of (page index << `page_shift`), then bits [15:8] of that value, then 0x00. `xfer_req` is a single-cycle strobe for each byte.
- R5: After each erase frame, the block issues status frames. Each status frame is exactly 2 bytes: 0xD7, then 0x00. The byte received during the second byte is the status, and its bit 7 set means ready. Polling repeats until the device is ready. Every frame has its own chip-select assertion, and `xfer_req` is only raised while chip select is high.
- R6: The page index advances by 8 after a block erase and by 1 after a page erase, until no pages remain. A zero length completes with `done` and sends no frame.
- R7: Chip select stays low for at least `poll_gap` cycles before every status frame.
- R8: When `poll_limit` consecutive status reads for one command report not-ready, the block raises `fail` and returns to idle with chip select low. A limit of 0 behaves as 1.
- R9: `done` and `fail` are single-cycle pulses, never high together, and `busy` is low in the cycle they are high.
- R10: After reset, `busy`, `done`, `fail`, `spi_cs` and `xfer_req` are low.
- R11: A `start` pulse while `busy` is high is ignored. The erase sequence in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| start_addr | input | ADDR_W | First byte to erase |
| erase_len | input | ADDR_W | Number of bytes to erase |
| dev_bytes | input | ADDR_W+1 | Device size in bytes |
| page_size | input | PS_W | Bytes per page |
| page_shift | input | SH_W | Left shift from page index to device address |
| poll_gap | input | IVL_W | Minimum idle cycles before a status frame |
| poll_limit | input | TO_W | Not-ready reads allowed per command |
| busy | output | 1 | Request in progress |
| done | output | 1 | Range erased (pulse) |
| fail | output | 1 | Rejected or timed out (pulse) |
| spi_cs | output | 1 | Chip select, active high |
| xfer_req | output | 1 | Byte transfer strobe |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Byte transfer complete strobe |
| xfer_rx | input | 8 | Byte received |

## Verification
The bench builds the block with a 12-bit address, a 4-bit page size, a 4-bit poll spacing and a 4-bit poll limit. At these widths the dividers finish in a dozen cycles, and a sweep of every start page 0 to 11 against every length of 0 to 10 pages can run. The sweep uses a 6-byte page and an 8-byte page. It covers each pattern of block and page erase around the eight-page alignment, and a shift of 13 pushes the address into the top command byte. Separate runs cover the rejection cases, the poll timeout, a zero poll spacing and a start strobe that arrives mid-run.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
   localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
   localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
   localparam logic [7:0] OP_STATUS      = 8'hD7;
   localparam int         BLOCK_PAGES    = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DIV,
      S_SEND,
      S_WAIT,
      S_GAP,
      S_IVL
   } seq_state_t;
endpackage

// File: rtl/flash_erase_div.sv
// Serial restoring divider: one quotient bit per cycle.
module flash_erase_div #(
   parameter int W  = 24,
   parameter int DW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [W-1:0]  dividend,
   input  logic [DW-1:0] divisor,
   output logic          done,
   output logic [W-1:0]  quo,
   output logic [DW-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   if (W < 2 || DW < 1) begin : g_bad_width
      $error("flash_erase_div: W must be >= 2 and DW >= 1");
   end

   logic [CW-1:0] cnt;
   logic [DW-1:0] dv;
   logic [DW:0]   trial;

   assign trial = {rem, quo[W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         quo  <= '0;
         rem  <= '0;
         dv   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            cnt <= CW'(W);
            quo <= dividend;
            rem <= '0;
            dv  <= divisor;
         end else if (cnt != '0) begin
            if (trial >= {1'b0, dv}) begin
               rem <= DW'(trial - {1'b0, dv});
               quo <= {quo[W-2:0], 1'b1};
            end else begin
               rem <= trial[DW-1:0];
               quo <= {quo[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/flash_erase_gap_timer.sv
// Down counter that spaces status polls.
module flash_erase_gap_timer #(
   parameter int IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IVL_W-1:0] len,
   output logic             zero
);
   logic [IVL_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= len;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int PS_W   = 11,
   parameter int SH_W   = 4,
   parameter int IVL_W  = 16,
   parameter int TO_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] erase_len,
   input  logic [ADDR_W:0]   dev_bytes,
   input  logic [PS_W-1:0]   page_size,
   input  logic [SH_W-1:0]   page_shift,
   input  logic [IVL_W-1:0]  poll_gap,
   input  logic [TO_W-1:0]   poll_limit,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              spi_cs,
   output logic              xfer_req,
   output logic [7:0]        xfer_tx,
   input  logic              xfer_done,
   input  logic [7:0]        xfer_rx
);
   localparam int WIDE_W = ADDR_W + (1 << SH_W);

   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr
      $error("flash_erase_seq: ADDR_W must lie in 4..24");
   end
   if (PS_W < 1 || PS_W > ADDR_W) begin : g_bad_ps
      $error("flash_erase_seq: PS_W must lie in 1..ADDR_W");
   end
   if (SH_W < 1 || SH_W > 5 || IVL_W < 1 || TO_W < 1) begin : g_bad_misc
      $error("flash_erase_seq: SH_W in 1..5, IVL_W and TO_W at least 1");
   end

   seq_state_t        state;
   logic [ADDR_W-1:0] page_q, left_q, step;
   logic [SH_W-1:0]   sh_q;
   logic [IVL_W-1:0]  gap_q;
   logic [TO_W-1:0]   lim_q, tries;
   logic [1:0]        byte_idx;
   logic              is_poll, use_block, reject, last_byte;
   logic [7:0]        stat_q;
   logic [15:0]       pa_hi;
   logic              tmr_zero;

   // Two dividers: index 0 converts the start, index 1 the length.
   logic [ADDR_W-1:0] div_in  [2];
   logic [ADDR_W-1:0] div_quo [2];
   logic [PS_W-1:0]   div_rem [2];
   logic              div_done[2];
   logic              div_go;

   assign div_in[0] = start_addr;
   assign div_in[1] = erase_len;

   for (genvar k = 0; k < 2; k++) begin : g_div
      flash_erase_div #(.W(ADDR_W), .DW(PS_W)) i_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (div_go),
         .dividend (div_in[k]),
         .divisor  (page_size),
         .done     (div_done[k]),
         .quo      (div_quo[k]),
         .rem      (div_rem[k])
      );
   end

   flash_erase_gap_timer #(.IVL_W(IVL_W)) i_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state == S_GAP),
      .len   (gap_q),
      .zero  (tmr_zero)
   );

   assign reject = (({1'b0, start_addr} + {1'b0, erase_len}) > dev_bytes)
                   || (page_size == '0);
   assign div_go = (state == S_IDLE) && start && !reject;

   assign use_block = (page_q[2:0] == 3'd0) && (left_q >= ADDR_W'(BLOCK_PAGES));
   assign step      = use_block ? ADDR_W'(BLOCK_PAGES) : ADDR_W'(1);
   assign pa_hi     = 16'((WIDE_W'(page_q) << sh_q) >> 8);
   assign last_byte = is_poll ? (byte_idx == 2'd1) : (byte_idx == 2'd3);

   always_comb begin
      xfer_tx = 8'h00;
      if (is_poll) begin
         if (byte_idx == 2'd0) xfer_tx = OP_STATUS;
      end else begin
         case (byte_idx)
            2'd0:    xfer_tx = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
            2'd1:    xfer_tx = pa_hi[15:8];
            2'd2:    xfer_tx = pa_hi[7:0];
            default: xfer_tx = 8'h00;
         endcase
      end
   end

   assign busy     = (state != S_IDLE);
   assign spi_cs   = (state == S_SEND) || (state == S_WAIT);
   assign xfer_req = (state == S_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         page_q   <= '0;
         left_q   <= '0;
         sh_q     <= '0;
         gap_q    <= '0;
         lim_q    <= '0;
         tries    <= '0;
         byte_idx <= '0;
         is_poll  <= 1'b0;
         stat_q   <= '0;
         done     <= 1'b0;
         fail     <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               sh_q  <= page_shift;
               gap_q <= poll_gap;
               lim_q <= poll_limit;
               if (reject) fail  <= 1'b1;
               else        state <= S_DIV;
            end
            S_DIV: if (div_done[0]) begin
               if (div_rem[0] != '0 || div_rem[1] != '0) begin
                  fail  <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  page_q <= div_quo[0];
                  left_q <= div_quo[1];
                  if (div_quo[1] == '0) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     is_poll  <= 1'b0;
                     byte_idx <= '0;
                     state    <= S_SEND;
                  end
               end
            end
            S_SEND: state <= S_WAIT;
            S_WAIT: if (xfer_done) begin
               if (last_byte) begin
                  stat_q <= xfer_rx;
                  state  <= S_GAP;
               end else begin
                  byte_idx <= byte_idx + 2'd1;
                  state    <= S_SEND;
               end
            end
            S_GAP: begin
               byte_idx <= '0;
               if (!is_poll) begin
                  tries <= '0;
                  state <= S_IVL;
               end else if (stat_q[7]) begin
                  page_q <= page_q + step;
                  left_q <= left_q - step;
                  if (left_q == step) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     is_poll <= 1'b0;
                     state   <= S_SEND;
                  end
               end else if (({1'b0, tries} + 1'b1) >= {1'b0, lim_q}) begin
                  fail  <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  tries <= tries + 1'b1;
                  state <= S_IVL;
               end
            end
            S_IVL: if (tmr_zero) begin
               is_poll <= 1'b1;
               state   <= S_SEND;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic fail,
   input logic spi_cs,
   input logic xfer_req
);
   p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (!busy && !spi_cs));

   p_req_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> spi_cs);

   p_req_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!spi_cs && !xfer_req));
endmodule

bind flash_erase_seq flash_erase_seq_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .fail     (fail),
   .spi_cs   (spi_cs),
   .xfer_req (xfer_req)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
   localparam int AW = 12, PSW = 4, SHW = 4, IW = 4, TW = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] start_addr = '0, erase_len = '0;
   logic [AW:0]   dev_bytes = '0;
   logic [PSW-1:0] page_size = '0;
   logic [SHW-1:0] page_shift = '0;
   logic [IW-1:0]  poll_gap = '0;
   logic [TW-1:0]  poll_limit = '0;
   logic busy, done, fail, spi_cs, xfer_req;
   logic [7:0] xfer_tx;
   logic xfer_done = 1'b0;
   logic [7:0] xfer_rx = 8'h00;

   int tests = 0, fails = 0;

   always #10 clk = ~clk;

   flash_erase_seq #(.ADDR_W(AW), .PS_W(PSW), .SH_W(SHW), .IVL_W(IW), .TO_W(TW)) i_flash_erase_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .erase_len(erase_len), .dev_bytes(dev_bytes), .page_size(page_size),
      .page_shift(page_shift), .poll_gap(poll_gap), .poll_limit(poll_limit),
      .busy(busy), .done(done), .fail(fail), .spi_cs(spi_cs),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx)
   );

   // ---------------- flash and SPI byte model ----------------
   int busy_polls = 0, cur_gap = 0;
   int lat = 0, fidx = 0, low_cnt = 0, polls_cmd = 0;
   int n_ob = 0, n_poll = 0, bad_len = 0, bad_gap = 0;
   logic prev_cs = 1'b0;
   logic [7:0] fb [0:7];
   logic [7:0] rx_next = 8'h00;
   logic [7:0] ob_op [0:63];
   logic [7:0] ob_b1 [0:63];
   logic [7:0] ob_b2 [0:63];
   logic [7:0] ob_b3 [0:63];

   always @(negedge clk) begin
      xfer_done = 1'b0;
      if (lat > 0) begin
         lat = lat - 1;
         if (lat == 0) begin xfer_done = 1'b1; xfer_rx = rx_next; end
      end
      if (spi_cs && !prev_cs) begin
         fidx = 0;
         if (xfer_tx == 8'hD7 && low_cnt < cur_gap) bad_gap++;
      end
      if (!spi_cs && prev_cs) begin
         if (fb[0] == 8'hD7) begin
            if (fidx != 2) bad_len++;
            n_poll++;
            polls_cmd++;
         end else begin
            if (fidx != 4) bad_len++;
            if (n_ob < 64) begin
               ob_op[n_ob] = fb[0]; ob_b1[n_ob] = fb[1];
               ob_b2[n_ob] = fb[2]; ob_b3[n_ob] = fb[3];
            end
            n_ob++;
            polls_cmd = 0;
         end
      end
      if (xfer_req) begin
         if (fidx < 8) fb[fidx] = xfer_tx;
         if (fidx == 1 && fb[0] == 8'hD7)
            rx_next = (polls_cmd >= busy_polls) ? 8'h80 : 8'h3C;
         else
            rx_next = 8'hFF;
         fidx++;
         lat = 2;
      end
      if (!spi_cs) low_cnt++; else low_cnt = 0;
      prev_cs = spi_cs;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // outcome: 1 done, 2 fail, 0 hang
   task automatic run(input int st, input int ln, input int dv, input int ps, input int sh,
                      input int gp, input int lim, input int bp, input bit poke,
                      output int res);
      @(negedge clk);
      n_ob = 0; n_poll = 0; bad_len = 0; bad_gap = 0; polls_cmd = 0;
      busy_polls = bp; cur_gap = gp;
      start_addr = AW'(st); erase_len = AW'(ln); dev_bytes = (AW+1)'(dv);
      page_size = PSW'(ps); page_shift = SHW'(sh);
      poll_gap = IW'(gp); poll_limit = TW'(lim);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      res = 0;
      for (int c = 0; c < 20000; c++) begin
         if (done) begin res = 1; break; end
         if (fail) begin res = 2; break; end
         if (poke && c == 40) begin
            start_addr = '0; erase_len = AW'(ps); page_shift = '0;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(!(done && fail), "R9 done/fail exclusive", int'(done), 0);
      chk(!busy, "R9 busy low with end pulse", int'(busy), 0);
      @(negedge clk);
      chk(!done && !fail, "R9 end pulse one cycle", int'(done | fail), 0);
   endtask

   task automatic check_run(input int st, input int ln, input int dv, input int ps, input int sh,
                            input int gp, input int bp, input bit poke, input string tag);
      int res, p, l, n, pa;
      bit bad, blk;
      logic [7:0] e_op [0:63];
      logic [7:0] e_b1 [0:63];
      logic [7:0] e_b2 [0:63];
      bad = (st + ln > dv) || (ps == 0);
      if (!bad) bad = (st % ps != 0) || (ln % ps != 0);
      n = 0;
      if (!bad) begin
         p = st / ps; l = ln / ps;
         while (l > 0) begin
            blk = (p % 8 == 0) && (l >= 8);
            pa  = (p << sh) & 32'hFF_FFFF;
            e_op[n] = blk ? 8'h50 : 8'h81;
            e_b1[n] = 8'((pa >> 16) & 255);
            e_b2[n] = 8'((pa >> 8) & 255);
            n++;
            p += blk ? 8 : 1;
            l -= blk ? 8 : 1;
         end
      end
      run(st, ln, dv, ps, sh, gp, 15, bp, poke, res);
      chk(res == (bad ? 2 : 1), {tag, " outcome"}, res, bad ? 2 : 1);
      chk(n_ob == n, {tag, " R6 erase command count"}, n_ob, n);
      if (n_ob == n) begin
         for (int i = 0; i < n; i++) begin
            chk(ob_op[i] == e_op[i], {tag, " R3 opcode"}, int'(ob_op[i]), int'(e_op[i]));
            chk(ob_b1[i] == e_b1[i] && ob_b2[i] == e_b2[i] && ob_b3[i] == 8'h00,
                {tag, " R4 address bytes"}, int'({ob_b1[i], ob_b2[i], ob_b3[i]}),
                int'({e_b1[i], e_b2[i], 8'h00}));
         end
      end
      chk(n_poll == n * (bp + 1), {tag, " R5 status poll count"}, n_poll, n * (bp + 1));
      chk(bad_len == 0, {tag, " R5 frame length"}, bad_len, 0);
      chk(bad_gap == 0, {tag, " R7 poll spacing"}, bad_gap, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      int res;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fail && !spi_cs && !xfer_req, "R10 reset state",
          int'({busy, done, fail, spi_cs, xfer_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !spi_cs, "R10 idle after reset", int'({busy, spi_cs}), 0);

      // sweep: 6-byte pages shift 3, 8-byte pages shift 13
      for (int cfg = 0; cfg < 2; cfg++) begin
         for (int sp = 0; sp < 12; sp++) begin
            for (int lp = 0; lp <= 10; lp++) begin
               int ps = (cfg == 0) ? 6 : 8;
               check_run(sp * ps, lp * ps, 32 * ps, ps, (cfg == 0) ? 3 : 13,
                         3, 1, 1'b0, "R3 R4 R6 sweep");
            end
         end
      end

      // rejections
      check_run(60, 42, 96, 6, 3, 3, 1, 1'b0, "R1 out of bounds");
      check_run(48, 48, 96, 6, 3, 3, 1, 1'b0, "R1 exact end in bounds");
      check_run(19, 12, 96, 6, 3, 3, 1, 1'b0, "R2 misaligned start");
      check_run(18, 13, 96, 6, 3, 3, 1, 1'b0, "R2 misaligned length");
      check_run(0, 8, 96, 0, 3, 3, 1, 1'b0, "R2 zero page size");
      check_run(0, 0, 96, 6, 3, 3, 1, 1'b0, "R6 zero length");

      // spacing and polling variants
      check_run(0, 80, 256, 8, 4, 0, 0, 1'b0, "R7 zero gap");
      check_run(16, 72, 256, 8, 4, 9, 4, 1'b0, "R5 R7 long busy");

      // start while busy ignored
      check_run(24, 80, 256, 8, 9, 3, 2, 1'b1, "R11 start while busy");

      // timeout
      run(0, 8, 256, 8, 3, 2, 3, 50, 1'b0, res);
      chk(res == 2, "R8 timeout fail", res, 2);
      chk(n_poll == 3, "R8 timeout poll count", n_poll, 3);
      chk(!spi_cs, "R8 cs low after timeout", int'(spi_cs), 0);
      run(0, 8, 256, 8, 3, 2, 0, 50, 1'b0, res);
      chk(res == 2 && n_poll == 1, "R8 zero limit acts as one", n_poll, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule